// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-register operations of a small 32-bit RISC core. One request per cycle arrives with a base operand, a 16-bit immediate, write data and the current value of the destination register. The block forms a register address from the base and the immediate and decodes it into a grouped address space. That space holds the processor state registers (status, program counters, exception registers) and read-only configuration words. It also holds the match and translate arrays of the first way of a data TLB and an instruction TLB.

Writes can have side effects. A status write that alters a translation-enable bit or the supervisor bit asks for a full TLB flush. A TLB match write that clears the valid bit asks for a flush of the page the entry used to map. Writes to the interrupt controller and tick timer registers leave the block as strobes, and reads of those registers return values that the external units supply. Reads are combinational and leave the destination value unchanged for any address that is not implemented.

A request is a single-cycle valid pulse. There is no ready signal: the block accepts a request in every cycle and never applies back-pressure, because a read completes in the cycle it is presented and a write completes at the next clock edge.

Top module: `spr_unit`

## Requirements
- R1: The register address is `base_op | {16'h0, imm}`, a bitwise OR and not a sum. Bits [15:11] are the group and bits [10:0] are the index. Any address with a nonzero bit in [31:16] is unimplemented.
- R2: In group 0 the version (0), next-PC (16), status (17), previous-PC (18), exception PC (32), effective address (48) and exception status (64) registers store a write at the clock edge and return it on later reads.
- R3: A read of the version register returns the stored value ANDed with `VER_MASK`, which defaults to 32'hFF00_003F.
- R4: Group 0 indices 1 to 4 return the parameters `UPR_VAL`, `CPUCFG_VAL`, `DMMUCFG_VAL` and `IMMUCFG_VAL`. Writes to these indices change nothing.
- R5: Status bit 15 always reads as 1, whatever value is written.
- R6: A status write that changes bit 0 (supervisor), bit 5 (data translation enable) or bit 6 (instruction translation enable) raises `tlb_flush_all` for exactly the cycle after the write edge. A status write that changes none of these bits raises no pulse.
- R7: Group 1 (data TLB) and group 2 (instruction TLB) each hold `TLB_ENTRIES` (default 128) match words at indices 512 to 639 and the same number of translate words at 640 to 767. The entry is the index minus the start of its range, and the two TLBs are independent.
- R8: A match write with bit 0 clear raises `page_flush` for the cycle after the write edge. `page_flush_addr` is then the entry's previous match value with its low 13 bits cleared (8 KiB pages). A match write with bit 0 set raises no pulse.
- R9: Indices 768 to 1535 of groups 1 and 2, and every other unimplemented address, return `old_dest` on a read and change no state on a write.
- R10: A write to group 9 index 0 or 2, or to group 10 index 0 or 1, raises the matching strobe (`pic_mask_we`, `pic_stat_we`, `tmr_mode_we`, `tmr_cnt_we`) in the same cycle, with `ext_wdata` equal to `wr_data`. A read of one of these addresses returns the matching `*_in` port.
- R11: After reset the status register reads 32'h0000_8000, the other writable registers and the TLB arrays read 0, and no flush pulse is high.
- R12: With `req_valid` low, no state changes, no strobe is raised and no flush pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| base_op | input | 32 | Base operand of the address |
| imm | input | 16 | Immediate ORed into the address |
| wr_data | input | 32 | Data to write |
| old_dest | input | 32 | Current value of the destination register |
| rd_data | output | 32 | Read result, combinational |
| tlb_flush_all | output | 1 | Full TLB flush pulse |
| page_flush | output | 1 | Single-page flush pulse |
| page_flush_addr | output | 32 | Page-aligned address to flush |
| pic_mask_we | output | 1 | Interrupt mask write strobe |
| pic_stat_we | output | 1 | Interrupt status write strobe |
| tmr_mode_we | output | 1 | Timer mode write strobe |
| tmr_cnt_we | output | 1 | Timer count write strobe |
| ext_wdata | output | 32 | Data carried with the external strobes |
| pic_mask_in | input | 32 | Current interrupt mask |
| pic_stat_in | input | 32 | Current interrupt status |
| tmr_mode_in | input | 32 | Current timer mode |
| tmr_cnt_in | input | 32 | Current timer count |

## Verification
The bench presents a base and an immediate whose OR and sum name different registers, so a design that adds them reads the previous-PC instead of the status register. It writes status words that change only bits outside the flush set, and a design that compares the whole word would then flush when it must not. It clears a match entry that held an unaligned value, and a design that reports the new value or forgets the page mask would flush the wrong page. It also writes into the way-1 range whose index would alias entry 0 if truncated, and checks that the way-0 arrays stay at zero, that a write without `req_valid` changes nothing, and that the external strobes fire one at a time.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [4:0] {
    K_NONE, K_VER, K_UPR, K_CPUCFG, K_DMMUCFG, K_IMMUCFG,
    K_NPC, K_SR, K_PPC, K_EPCR, K_EEAR, K_ESR,
    K_TLB_MATCH, K_TLB_XLATE,
    K_PIC_MASK, K_PIC_STAT, K_TMR_MODE, K_TMR_CNT
  } spr_kind_e;

  typedef struct packed {
    spr_kind_e kind;
    logic      tlb_instr;   // 0 = data TLB, 1 = instruction TLB
  } spr_dec_t;

  // status register bit positions
  localparam int SR_SM  = 0;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_FO  = 15;

  localparam logic [31:0] SR_FO_BIT    = 32'(1) << SR_FO;
  localparam logic [31:0] SR_XLAT_MASK = (32'(1) << SR_SM) | (32'(1) << SR_DME)
                                       | (32'(1) << SR_IME);

endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
#(
  parameter int TLB_ENTRIES = 128,
  parameter int ENT_W       = $clog2(TLB_ENTRIES)
) (
  input  logic [31:0]      base_op,
  input  logic [15:0]      imm,
  output spr_dec_t         dec,
  output logic [ENT_W-1:0] entry
);
  localparam logic [10:0] MATCH_BASE = 11'd512;
  localparam logic [10:0] XLATE_BASE = 11'(512 + TLB_ENTRIES);
  localparam logic [10:0] XLATE_END  = 11'(512 + 2 * TLB_ENTRIES);

  logic [31:0] addr;
  logic [4:0]  grp;
  logic [10:0] idx;

  always_comb begin
    addr  = base_op | {16'h0, imm};
    grp   = addr[15:11];
    idx   = addr[10:0];
    dec   = '{kind: K_NONE, tlb_instr: 1'b0};
    entry = '0;
    if (addr[31:16] == 16'h0) begin
      case (grp)
        5'd0: begin
          case (idx)
            11'd0:   dec.kind = K_VER;
            11'd1:   dec.kind = K_UPR;
            11'd2:   dec.kind = K_CPUCFG;
            11'd3:   dec.kind = K_DMMUCFG;
            11'd4:   dec.kind = K_IMMUCFG;
            11'd16:  dec.kind = K_NPC;
            11'd17:  dec.kind = K_SR;
            11'd18:  dec.kind = K_PPC;
            11'd32:  dec.kind = K_EPCR;
            11'd48:  dec.kind = K_EEAR;
            11'd64:  dec.kind = K_ESR;
            default: dec.kind = K_NONE;
          endcase
        end
        5'd1, 5'd2: begin
          dec.tlb_instr = (grp == 5'd2);
          if (idx >= MATCH_BASE && idx < XLATE_BASE) begin
            dec.kind = K_TLB_MATCH;
            entry    = ENT_W'(idx - MATCH_BASE);
          end else if (idx >= XLATE_BASE && idx < XLATE_END) begin
            dec.kind = K_TLB_XLATE;
            entry    = ENT_W'(idx - XLATE_BASE);
          end
        end
        5'd9: begin
          if (idx == 11'd0)      dec.kind = K_PIC_MASK;
          else if (idx == 11'd2) dec.kind = K_PIC_STAT;
        end
        5'd10: begin
          if (idx == 11'd0)      dec.kind = K_TMR_MODE;
          else if (idx == 11'd1) dec.kind = K_TMR_CNT;
        end
        default: dec.kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/spr_sys_regs.sv
module spr_sys_regs
  import spr_pkg::*;
#(
  parameter logic [31:0] VER_MASK = 32'hFF00_003F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  spr_kind_e   kind,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        flush_req
);
  logic [31:0] ver_q, npc_q, sr_q, ppc_q, epcr_q, eear_q, esr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ver_q  <= '0;
      npc_q  <= '0;
      sr_q   <= SR_FO_BIT;
      ppc_q  <= '0;
      epcr_q <= '0;
      eear_q <= '0;
      esr_q  <= '0;
    end else if (we) begin
      case (kind)
        K_VER:   ver_q  <= wdata;
        K_NPC:   npc_q  <= wdata;
        K_SR:    sr_q   <= wdata | SR_FO_BIT;
        K_PPC:   ppc_q  <= wdata;
        K_EPCR:  epcr_q <= wdata;
        K_EEAR:  eear_q <= wdata;
        K_ESR:   esr_q  <= wdata;
        default: ;
      endcase
    end
  end

  // translation or privilege change invalidates every cached mapping
  assign flush_req = we && (kind == K_SR) && (((sr_q ^ wdata) & SR_XLAT_MASK) != '0);

  always_comb begin
    case (kind)
      K_VER:   rdata = ver_q & VER_MASK;
      K_NPC:   rdata = npc_q;
      K_SR:    rdata = sr_q;
      K_PPC:   rdata = ppc_q;
      K_EPCR:  rdata = epcr_q;
      K_EEAR:  rdata = eear_q;
      K_ESR:   rdata = esr_q;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/spr_tlb_bank.sv
module spr_tlb_bank #(
  parameter int TLB_ENTRIES = 128,
  parameter int ENT_W       = $clog2(TLB_ENTRIES),
  parameter int PAGE_BITS   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_match,
  input  logic             we_xlate,
  input  logic [ENT_W-1:0] entry,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_match,
  output logic [31:0]      rd_xlate,
  output logic             pf_req,
  output logic [31:0]      pf_addr
);
  logic [31:0] match_q [TLB_ENTRIES];
  logic [31:0] xlate_q [TLB_ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TLB_ENTRIES; i++) begin
        match_q[i] <= '0;
        xlate_q[i] <= '0;
      end
    end else begin
      if (we_match) match_q[entry] <= wdata;
      if (we_xlate) xlate_q[entry] <= wdata;
    end
  end

  assign rd_match = match_q[entry];
  assign rd_xlate = xlate_q[entry];
  // old contents name the page to drop; the new word is stored at the same edge
  assign pf_req   = we_match && !wdata[0];
  assign pf_addr  = {match_q[entry][31:PAGE_BITS], {PAGE_BITS{1'b0}}};

endmodule

// File: rtl/spr_unit.sv
module spr_unit
  import spr_pkg::*;
#(
  parameter int          TLB_ENTRIES = 128,
  parameter int          PAGE_BITS   = 13,
  parameter logic [31:0] VER_MASK    = 32'hFF00_003F,
  parameter logic [31:0] UPR_VAL     = 32'h0000_0619,
  parameter logic [31:0] CPUCFG_VAL  = 32'h0000_0020,
  parameter logic [31:0] DMMUCFG_VAL = 32'h0000_0018,
  parameter logic [31:0] IMMUCFG_VAL = 32'h0000_0018
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [31:0] base_op,
  input  logic [15:0] imm,
  input  logic [31:0] wr_data,
  input  logic [31:0] old_dest,
  output logic [31:0] rd_data,
  output logic        tlb_flush_all,
  output logic        page_flush,
  output logic [31:0] page_flush_addr,
  output logic        pic_mask_we,
  output logic        pic_stat_we,
  output logic        tmr_mode_we,
  output logic        tmr_cnt_we,
  output logic [31:0] ext_wdata,
  input  logic [31:0] pic_mask_in,
  input  logic [31:0] pic_stat_in,
  input  logic [31:0] tmr_mode_in,
  input  logic [31:0] tmr_cnt_in
);
  localparam int ENT_W   = $clog2(TLB_ENTRIES);
  localparam int N_BANKS = 2;

  spr_dec_t         dec;
  logic [ENT_W-1:0] entry;
  logic             wr_fire;
  logic [31:0]      sys_rdata;
  logic             sys_flush;

  logic [31:0]        bk_match  [N_BANKS];
  logic [31:0]        bk_xlate  [N_BANKS];
  logic [31:0]        bk_pfaddr [N_BANKS];
  logic [N_BANKS-1:0] bk_pfreq;

  assign wr_fire = req_valid && req_write;

  spr_decode #(.TLB_ENTRIES(TLB_ENTRIES), .ENT_W(ENT_W)) u_dec (
    .base_op (base_op),
    .imm     (imm),
    .dec     (dec),
    .entry   (entry)
  );

  spr_sys_regs #(.VER_MASK(VER_MASK)) u_sys (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr_fire),
    .kind      (dec.kind),
    .wdata     (wr_data),
    .rdata     (sys_rdata),
    .flush_req (sys_flush)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (dec.tlb_instr == (b != 0));
    spr_tlb_bank #(.TLB_ENTRIES(TLB_ENTRIES), .ENT_W(ENT_W), .PAGE_BITS(PAGE_BITS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_match (wr_fire && sel && dec.kind == K_TLB_MATCH),
      .we_xlate (wr_fire && sel && dec.kind == K_TLB_XLATE),
      .entry    (entry),
      .wdata    (wr_data),
      .rd_match (bk_match[b]),
      .rd_xlate (bk_xlate[b]),
      .pf_req   (bk_pfreq[b]),
      .pf_addr  (bk_pfaddr[b])
    );
  end

  // external units capture on the same edge as internal registers
  assign pic_mask_we = wr_fire && dec.kind == K_PIC_MASK;
  assign pic_stat_we = wr_fire && dec.kind == K_PIC_STAT;
  assign tmr_mode_we = wr_fire && dec.kind == K_TMR_MODE;
  assign tmr_cnt_we  = wr_fire && dec.kind == K_TMR_CNT;
  assign ext_wdata   = wr_data;

  always_comb begin
    case (dec.kind)
      K_VER, K_NPC, K_SR, K_PPC, K_EPCR, K_EEAR, K_ESR: rd_data = sys_rdata;
      K_UPR:       rd_data = UPR_VAL;
      K_CPUCFG:    rd_data = CPUCFG_VAL;
      K_DMMUCFG:   rd_data = DMMUCFG_VAL;
      K_IMMUCFG:   rd_data = IMMUCFG_VAL;
      K_TLB_MATCH: rd_data = dec.tlb_instr ? bk_match[1] : bk_match[0];
      K_TLB_XLATE: rd_data = dec.tlb_instr ? bk_xlate[1] : bk_xlate[0];
      K_PIC_MASK:  rd_data = pic_mask_in;
      K_PIC_STAT:  rd_data = pic_stat_in;
      K_TMR_MODE:  rd_data = tmr_mode_in;
      K_TMR_CNT:   rd_data = tmr_cnt_in;
      default:     rd_data = old_dest;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tlb_flush_all   <= 1'b0;
      page_flush      <= 1'b0;
      page_flush_addr <= '0;
    end else begin
      tlb_flush_all <= sys_flush;
      page_flush    <= |bk_pfreq;
      if (bk_pfreq[1])      page_flush_addr <= bk_pfaddr[1];
      else if (bk_pfreq[0]) page_flush_addr <= bk_pfaddr[0];
    end
  end

endmodule

// File: rtl/spr_unit_chk.sv
module spr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [31:0] base_op,
  input logic [15:0] imm,
  input logic [31:0] wr_data,
  input logic [31:0] old_dest,
  input logic [31:0] rd_data,
  input logic        tlb_flush_all,
  input logic        page_flush,
  input logic        pic_mask_we,
  input logic        pic_stat_we,
  input logic        tmr_mode_we,
  input logic        tmr_cnt_we
);
  logic [31:0] a;
  logic        is_tlb_grp;
  assign a          = base_op | {16'h0, imm};
  assign is_tlb_grp = (a[31:16] == 16'h0) && (a[15:11] == 5'd1 || a[15:11] == 5'd2);

  assert_fixed_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && a == 32'd17) |-> rd_data[15]);

  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_all |-> $past(req_valid && req_write && a == 32'd17));

  assert_page_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    page_flush |-> $past(req_valid && req_write && is_tlb_grp && !wr_data[0]));

  assert_upper_ways_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && is_tlb_grp && a[10:0] >= 11'd768) |-> rd_data == old_dest);

  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pic_mask_we, pic_stat_we, tmr_mode_we, tmr_cnt_we}));

  assert_strobe_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pic_mask_we || pic_stat_we || tmr_mode_we || tmr_cnt_we) |-> (req_valid && req_write));

  assert_no_flush_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!req_valid) |-> !tlb_flush_all && !page_flush);

endmodule

bind spr_unit spr_unit_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .base_op       (base_op),
  .imm           (imm),
  .wr_data       (wr_data),
  .old_dest      (old_dest),
  .rd_data       (rd_data),
  .tlb_flush_all (tlb_flush_all),
  .page_flush    (page_flush),
  .pic_mask_we   (pic_mask_we),
  .pic_stat_we   (pic_stat_we),
  .tmr_mode_we   (tmr_mode_we),
  .tmr_cnt_we    (tmr_cnt_we)
);

// File: tb/spr_unit_tb_top.sv
module spr_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] base_op = '0, wr_data = '0, old_dest = '0;
  logic [15:0] imm = '0;
  logic [31:0] rd_data, page_flush_addr, ext_wdata;
  logic        tlb_flush_all, page_flush;
  logic        pic_mask_we, pic_stat_we, tmr_mode_we, tmr_cnt_we;
  logic [31:0] pic_mask_in = 32'hA5A5_0001, pic_stat_in = 32'h0000_00F0;
  logic [31:0] tmr_mode_in = 32'h4000_0010, tmr_cnt_in = 32'h1111_2222;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  spr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .base_op(base_op), .imm(imm), .wr_data(wr_data), .old_dest(old_dest),
    .rd_data(rd_data), .tlb_flush_all(tlb_flush_all), .page_flush(page_flush),
    .page_flush_addr(page_flush_addr), .pic_mask_we(pic_mask_we),
    .pic_stat_we(pic_stat_we), .tmr_mode_we(tmr_mode_we), .tmr_cnt_we(tmr_cnt_we),
    .ext_wdata(ext_wdata), .pic_mask_in(pic_mask_in), .pic_stat_in(pic_stat_in),
    .tmr_mode_in(tmr_mode_in), .tmr_cnt_in(tmr_cnt_in)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit v, input bit w, input logic [31:0] b,
                       input logic [15:0] i, input logic [31:0] d, input logic [31:0] od);
    @(posedge clk); #1;
    req_valid = v; req_write = w; base_op = b; imm = i; wr_data = d; old_dest = od;
  endtask

  // driver: read request plus expected result for the monitor
  task automatic rd(input logic [31:0] b, input logic [15:0] i, input logic [31:0] od,
                    input logic [31:0] exp, input string tag);
    drive(1, 0, b, i, 32'h0, od);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [31:0] b, input logic [15:0] i, input logic [31:0] d);
    drive(1, 1, b, i, d, 32'h0);
  endtask

  task automatic idle();
    drive(0, 0, 32'h0, 16'h0, 32'h0, 32'h0);
  endtask

  // monitor: compares every read result away from the clock edge
  always @(negedge clk) begin
    if (rst_n && req_valid && !req_write && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(rd_data === e, t, rd_data, e);
    end
  end

  task automatic pulse_check(input bit exp_all, input bit exp_pg,
                             input logic [31:0] exp_addr, input string tag);
    @(negedge clk);
    check(tlb_flush_all === exp_all, {tag, " flush_all"}, 32'(tlb_flush_all), 32'(exp_all));
    check(page_flush === exp_pg, {tag, " page_flush"}, 32'(page_flush), 32'(exp_pg));
    if (exp_pg)
      check(page_flush_addr === exp_addr, {tag, " page_addr"}, page_flush_addr, exp_addr);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    pulse_check(0, 0, 0, "R11 reset");
    rd(32'h0, 16'd17, 32'h0, 32'h0000_8000, "R11 status after reset");
    rd(32'h0, 16'd16, 32'hFFFF, 32'h0, "R11 npc after reset");
    rd(32'h800, 16'd517, 32'hFFFF, 32'h0, "R11 dtlb match after reset");

    // R12 write without valid does nothing
    drive(0, 1, 32'h0, 16'd16, 32'h99, 32'h0);
    @(negedge clk);
    check(pic_mask_we === 0, "R12 no strobe", 32'(pic_mask_we), 0);
    drive(0, 1, 32'h0, 16'h4800, 32'h5, 32'h0);
    @(negedge clk);
    check(pic_mask_we === 0, "R12 no strobe idle", 32'(pic_mask_we), 0);
    rd(32'h0, 16'd16, 32'h0, 32'h0, "R12 npc unchanged");

    // R2 group 0 registers
    wr(32'h0, 16'd16, 32'h0000_1234);
    wr(32'h0, 16'd18, 32'h0000_5678);
    wr(32'h0, 16'd32, 32'hCAFE_0000);
    wr(32'h0, 16'd48, 32'h0BAD_F00D);
    wr(32'h0, 16'd64, 32'h0000_0042);
    rd(32'h0, 16'd16, 32'h0, 32'h0000_1234, "R2 npc");
    rd(32'h0, 16'd18, 32'h0, 32'h0000_5678, "R2 ppc");
    rd(32'h0, 16'd32, 32'h0, 32'hCAFE_0000, "R2 epc");
    rd(32'h0, 16'd48, 32'h0, 32'h0BAD_F00D, "R2 eear");
    rd(32'h0, 16'd64, 32'h0, 32'h0000_0042, "R2 esr");

    // R3 version mask
    wr(32'h0, 16'd0, 32'hFFFF_FFFF);
    rd(32'h0, 16'd0, 32'h0, 32'hFF00_003F, "R3 version masked");

    // R4 configuration words are read-only
    wr(32'h0, 16'd2, 32'hDEAD_BEEF);
    rd(32'h0, 16'd2, 32'h0, 32'h0000_0020, "R4 cpucfg");
    rd(32'h0, 16'd1, 32'h0, 32'h0000_0619, "R4 upr");
    rd(32'h0, 16'd4, 32'h0, 32'h0000_0018, "R4 immucfg");

    // R6 / R5 status side effects
    wr(32'h0, 16'd17, 32'h0000_0061);
    idle();
    pulse_check(1, 0, 0, "R6 status change flush");
    rd(32'h0, 16'd17, 32'h0, 32'h0000_8061, "R5 status readback");
    wr(32'h0, 16'd17, 32'h0000_0261);
    idle();
    pulse_check(0, 0, 0, "R6 no flush other bits");
    rd(32'h0, 16'd17, 32'h0, 32'h0000_8261, "R5 fixed one forced");
    wr(32'h0, 16'd17, 32'h0000_0260);
    idle();
    pulse_check(1, 0, 0, "R6 supervisor bit flush");

    // R1 OR addressing: 0x11|0x01 = status, 0x11+0x01 would be previous-PC
    rd(32'h11, 16'h0001, 32'h0, 32'h0000_8260, "R1 or not add");
    rd(32'h0001_0000, 16'd17, 32'h7777, 32'h7777, "R1 upper bits unimplemented");

    // R7 / R8 TLB arrays
    wr(32'h800, 16'd517, 32'h0002_4001);
    idle();
    pulse_check(0, 0, 0, "R8 valid set no flush");
    rd(32'h0, 16'h0A05, 32'h0, 32'h0002_4001, "R7 dtlb match entry 5");
    wr(32'h800, 16'd517, 32'h0000_0000);
    idle();
    pulse_check(0, 1, 32'h0002_4000, "R8 dtlb page flush");
    rd(32'h800, 16'd517, 32'h0, 32'h0, "R7 dtlb match cleared");
    wr(32'h1000, 16'd767, 32'h0000_ABCD);
    rd(32'h1000, 16'd767, 32'h0, 32'h0000_ABCD, "R7 itlb xlate 127");
    rd(32'h800, 16'd767, 32'h0, 32'h0, "R7 dtlb xlate independent");
    wr(32'h1000, 16'd515, 32'h0003_7FFF);
    wr(32'h1000, 16'd515, 32'h1234_0000);
    idle();
    pulse_check(0, 1, 32'h0003_6000, "R8 itlb page flush old value");
    rd(32'h1000, 16'd515, 32'h0, 32'h1234_0000, "R7 itlb match new value");

    // R9 upper ways ignored
    rd(32'h800, 16'd768, 32'hDEAD_0001, 32'hDEAD_0001, "R9 way1 read");
    wr(32'h800, 16'd768, 32'h5555_5555);
    wr(32'h1000, 16'd1408, 32'h5555_5554);
    idle();
    pulse_check(0, 0, 0, "R9 way write no flush");
    rd(32'h800, 16'd512, 32'h0, 32'h0, "R9 dtlb match 0 untouched");
    rd(32'h800, 16'd640, 32'h0, 32'h0, "R9 dtlb xlate 0 untouched");
    rd(32'h0, 16'd5, 32'h3141_5926, 32'h3141_5926, "R9 group0 hole");

    // R10 external strobes
    wr(32'h0, 16'h4802, 32'h0000_0077);
    @(negedge clk);
    check(pic_stat_we === 1, "R10 pic status strobe", 32'(pic_stat_we), 1);
    check({pic_mask_we, tmr_mode_we, tmr_cnt_we} === 3'b000, "R10 other strobes",
          32'({pic_mask_we, tmr_mode_we, tmr_cnt_we}), 0);
    check(ext_wdata === 32'h77, "R10 strobe data", ext_wdata, 32'h77);
    wr(32'h5000, 16'h0001, 32'h0000_0009);
    @(negedge clk);
    check(tmr_cnt_we === 1, "R10 timer count strobe", 32'(tmr_cnt_we), 1);
    rd(32'h5000, 16'h0001, 32'h0, 32'h1111_2222, "R10 timer count read");
    rd(32'h4800, 16'h0000, 32'h0, 32'hA5A5_0001, "R10 pic mask read");
    idle();
    idle();

    check(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule